// File: doc/BRIEF.md
# Configurable Bus Cycle Controller

This block sits between a processor's core bus and on-chip targets that live in address zones: three static zones and one I/O zone. Each accepted request becomes a bus cycle whose length depends on the direction of the transfer and on settings held in the block's own memory-mapped control registers. Reads come in two base timings, normal (two clocks) and fast (one clock). Writes also come in two, late (two clocks) and early (three clocks). Each zone adds a programmable number of wait cycles directly after the address is driven. It also adds a programmable number of hold cycles at the end of the cycle, during which the data stays on the bus.

The processor side is a request/ready handshake. The processor raises `cpu_req` together with the address, direction and write data, and holds all of them steady until `cpu_rdy` pulses. The block takes no new request in the clock that carries `cpu_rdy`, so the next request is accepted at the clock edge after that. Back-pressure is the length of the cycle itself: the processor may not withdraw or change a request before it completes. Control registers answer in a single clock. Addresses that no zone claims finish as a two-clock access that returns zero and flags an error.

Top module: `bcc_top`

## Requirements
- R1: After reset the global register reads 0x0007: bit 0 = 1 selects early writes, and bits 1 and 2 read 1. Every zone register reads 0x001F: wait field bits [2:0] = 7, hold field bits [4:3] = 3, fast-read bit 5 = 0.
- R2: The control registers sit in a 16-byte page at CREG_BASE (default 0xFF00). Offset 0 is the global register, offsets 2, 4 and 6 are static zones 0 to 2, and offset 8 is the I/O zone. Each register access completes in exactly 1 clock and asserts neither `bus_rd` nor `bus_wr`.
- R3: Reserved bits ignore writes. Global bits 1 and 2 always read 1, and the other global bits above bit 0 read 0. Zone register bits 15:6 read 0.
- R4: A zone read lasts 2+W+H clocks with fast-read = 0, and 1+W+H clocks with fast-read = 1. W and H are the wait and hold fields of that zone.
- R5: A zone write lasts 3+W+H clocks when global bit 0 = 1 (early write), and 2+W+H clocks when it is 0 (late write). The write data appears on `bus_wdata` with `bus_wr` high.
- R6: `bus_wait` is high for exactly W clocks, starting in the second clock of the access, right after the address clock. `bus_addr` stays stable for the whole access.
- R7: `bus_hold` is high for exactly the last H clocks of a zone access and is never high together with `bus_wait`. A read returns the data sampled in the last clock before the hold clocks, even if the target changes `bus_rdata` during hold.
- R8: `cpu_rdy` is high for exactly one clock, the last clock of the access. A request that is held through that clock is accepted at the following edge, so two back-to-back 1-clock accesses complete 2 clocks apart.
- R9: Addresses with bit 15 = 0 select zone `addr[14:13]`, where 3 is the I/O zone. During the access `bus_sel` is one-hot with bit `addr[14:13]` set.
- R10: Any other address lasts exactly 2 clocks and returns 0 on reads. Such addresses include bit 15 = 1 outside the control page, odd offsets, and offsets above 8. `cpu_err` is high only in the clock that `cpu_rdy` is high, and no bus strobe or select is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | DW | Write data |
| cpu_rdy | output | 1 | One-clock completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_rdy` |
| cpu_err | output | 1 | Unmapped-address flag, with `cpu_rdy` |
| bus_sel | output | NZONE | One-hot zone select |
| bus_addr | output | AW | Target address |
| bus_rd | output | 1 | Target read strobe |
| bus_wr | output | 1 | Target write strobe |
| bus_wdata | output | DW | Target write data |
| bus_wait | output | 1 | Marks wait clocks |
| bus_hold | output | 1 | Marks hold clocks |
| bus_rdata | input | DW | Target read data |

## Verification
The bench sweeps every zone across both read timings and every wait and hold count. It also sweeps both write timings and every wait and hold count on one zone, and checks cycle length, wait and hold placement and the returned data. A design that counted the base, wait and hold cycles off by one, or dropped one of them, would show the wrong length. During hold the target deliberately drives garbage, so a design that sampled late would return the wrong word. Further checks cover reserved-bit writes, the slowest reset settings, unmapped addresses in the control page, and a request held through the ready clock. A design that wrote reserved bits, flagged errors on valid accesses, or accepted a request in the ready clock would fail them.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int NZONE  = 4;
  localparam int ZSEL_W = $clog2(NZONE);
  localparam int RIDX_W = $clog2(NZONE + 1);
  localparam int WAIT_W = 3;
  localparam int HOLD_W = 2;
  localparam int CFG_W  = WAIT_W + HOLD_W + 1;

  typedef struct packed {
    logic              fast;
    logic [HOLD_W-1:0] hold;
    logic [WAIT_W-1:0] wait_n;
  } zone_cfg_t;

  typedef enum logic [1:0] {
    TGT_ZONE = 2'd0,
    TGT_CREG = 2'd1,
    TGT_NONE = 2'd2
  } tgt_kind_t;

  localparam zone_cfg_t ZONE_RST = '{fast: 1'b0, hold: '1, wait_n: '1};
  localparam logic [7:0] GCFG_RST = 8'h07;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] CREG_BASE = 16'hFF00
) (
  input  logic [AW-1:0]     addr,
  output tgt_kind_t         kind,
  output logic [ZSEL_W-1:0] zone_idx,
  output logic [RIDX_W-1:0] reg_idx
);
  localparam int PAGE_LSB = RIDX_W + 1;

  always_comb begin
    kind     = TGT_NONE;
    zone_idx = '0;
    reg_idx  = '0;
    if (addr[AW-1:PAGE_LSB] == CREG_BASE[AW-1:PAGE_LSB]) begin
      if (!addr[0] && (addr[PAGE_LSB-1:1] <= RIDX_W'(NZONE))) begin
        kind    = TGT_CREG;
        reg_idx = addr[PAGE_LSB-1:1];
      end
    end else if (!addr[AW-1]) begin
      kind     = TGT_ZONE;
      zone_idx = addr[AW-2 -: ZSEL_W];
    end
  end
endmodule

// File: rtl/bcc_regs.sv
module bcc_regs
  import bcc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RIDX_W-1:0]     reg_idx,
  input  logic [CFG_W-1:0]      wdata,
  output logic                  ewr,
  output zone_cfg_t [NZONE-1:0] zone_cfg,
  output logic [DW-1:0]         rd_data
);
  logic ewr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ewr_q <= GCFG_RST[0];
    else if (wr_en && reg_idx == '0)
      ewr_q <= wdata[0];
  end

  for (genvar g = 0; g < NZONE; g++) begin : g_zone
    zone_cfg_t cfg_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q <= ZONE_RST;
      else if (wr_en && reg_idx == RIDX_W'(g + 1))
        cfg_q <= zone_cfg_t'(wdata);
    end
    assign zone_cfg[g] = cfg_q;
  end

  assign ewr = ewr_q;

  always_comb begin
    if (reg_idx == '0)
      rd_data = DW'({GCFG_RST[7:1], ewr_q});
    else
      rd_data = DW'(zone_cfg[ZSEL_W'(reg_idx - RIDX_W'(1))]);
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] ld_wait,
  input  logic [CW-1:0] ld_core,
  input  logic [CW-1:0] ld_total,
  output logic          busy,
  output logic          last,
  output logic          in_wait,
  output logic          in_hold,
  output logic          sample
);
  logic          busy_q;
  logic [CW-1:0] cnt_q, wait_q, core_q, tot_q;

  assign last    = busy_q && (cnt_q == tot_q - CW'(1));
  assign in_wait = busy_q && (cnt_q != '0) && (cnt_q <= wait_q);
  assign in_hold = busy_q && (cnt_q >= core_q);
  assign sample  = busy_q && (cnt_q == core_q - CW'(1));
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wait_q <= '0;
      core_q <= '0;
      tot_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      wait_q <= ld_wait;
      core_q <= ld_core;
      tot_q  <= ld_total;
    end else if (busy_q) begin
      if (last)
        busy_q <= 1'b0;
      else
        cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/bcc_top.sv
module bcc_top
  import bcc_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] CREG_BASE = 16'hFF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_rdy,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_err,
  output logic [NZONE-1:0] bus_sel,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [DW-1:0]    bus_wdata,
  output logic             bus_wait,
  output logic             bus_hold,
  input  logic [DW-1:0]    bus_rdata
);
  localparam int MAXT = 3 + (2 ** WAIT_W - 1) + (2 ** HOLD_W - 1);
  localparam int CW   = $clog2(MAXT + 1);

  tgt_kind_t             dec_kind, kind_q;
  logic [ZSEL_W-1:0]     dec_zone, zone_q;
  logic [RIDX_W-1:0]     dec_reg, reg_q;
  logic                  we_q;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         wdata_q, rdata_q, reg_rd;
  zone_cfg_t [NZONE-1:0] zone_cfg;
  zone_cfg_t             zc;
  logic                  ewr, busy, last, in_wait, in_hold, sample, accept;
  logic [CW-1:0]         n_base, n_wait, n_hold, n_core, n_total;

  bcc_decode #(.AW(AW), .CREG_BASE(CREG_BASE)) u_dec (
    .addr(cpu_addr), .kind(dec_kind), .zone_idx(dec_zone), .reg_idx(dec_reg)
  );

  bcc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(last && we_q && kind_q == TGT_CREG),
    .reg_idx(reg_q), .wdata(wdata_q[CFG_W-1:0]),
    .ewr(ewr), .zone_cfg(zone_cfg), .rd_data(reg_rd)
  );

  assign accept = cpu_req && !busy;
  assign zc     = zone_cfg[dec_zone];

  always_comb begin
    n_wait = '0;
    n_hold = '0;
    case (dec_kind)
      TGT_CREG: n_base = CW'(1);
      TGT_ZONE: begin
        if (cpu_we) n_base = ewr ? CW'(3) : CW'(2);
        else        n_base = zc.fast ? CW'(1) : CW'(2);
        n_wait = CW'(zc.wait_n);
        n_hold = CW'(zc.hold);
      end
      default:  n_base = CW'(2);
    endcase
    n_core  = n_base + n_wait;
    n_total = n_core + n_hold;
  end

  bcc_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .ld_wait(n_wait), .ld_core(n_core), .ld_total(n_total),
    .busy(busy), .last(last), .in_wait(in_wait), .in_hold(in_hold),
    .sample(sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= TGT_NONE;
      zone_q  <= '0;
      reg_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        kind_q  <= dec_kind;
        zone_q  <= dec_zone;
        reg_q   <= dec_reg;
        we_q    <= cpu_we;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end
      if (sample && kind_q == TGT_ZONE && !we_q)
        rdata_q <= bus_rdata;
    end
  end

  logic zone_act;
  assign zone_act = busy && kind_q == TGT_ZONE;

  assign bus_sel   = zone_act ? (NZONE'(1) << zone_q) : '0;
  assign bus_addr  = addr_q;
  assign bus_rd    = zone_act && !we_q;
  assign bus_wr    = zone_act && we_q;
  assign bus_wdata = bus_wr ? wdata_q : '0;
  assign bus_wait  = zone_act && in_wait;
  assign bus_hold  = zone_act && in_hold;
  assign cpu_rdy   = last;
  assign cpu_err   = last && kind_q == TGT_NONE;

  always_comb begin
    cpu_rdata = '0;
    if (last && !we_q) begin
      case (kind_q)
        TGT_CREG: cpu_rdata = reg_rd;
        TGT_ZONE: cpu_rdata = in_hold ? rdata_q : bus_rdata;
        default:  cpu_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int AW    = 16,
  parameter int NZONE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rdy,
  input logic             cpu_err,
  input logic [NZONE-1:0] bus_sel,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             bus_wait,
  input logic             bus_hold
);
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy); // R8
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_rdy); // R10
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> (bus_sel == '0 && !bus_rd && !bus_wr)); // R10
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel)); // R9
  AST_STROBE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> $countones(bus_sel) == 1); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !cpu_rdy) |=> ($stable(bus_addr) && (bus_rd || bus_wr))); // R6
  AST_WAIT_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wait && bus_hold)); // R7
  AST_HOLD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hold && !cpu_rdy) |=> bus_hold); // R7
endmodule

bind bcc_top bcc_checker #(.AW(AW), .NZONE(bcc_pkg::NZONE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rdy(cpu_rdy), .cpu_err(cpu_err),
  .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wait(bus_wait), .bus_hold(bus_hold)
);

// File: tb/bcc_top_test.sv
module bcc_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr, cpu_wdata;
  logic        cpu_rdy, cpu_err;
  logic [15:0] cpu_rdata;
  logic [3:0]  bus_sel;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_wait, bus_hold;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int          r_cyc, r_nwait, r_nhold, r_fw;
  logic        r_strobe, r_err, r_after, r_bwr, r_brd;
  logic [15:0] r_rd, r_bwd;
  logic [3:0]  r_sel;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  // target model: garbage during hold, address-derived data otherwise
  assign bus_rdata = bus_hold ? 16'hDEAD : (bus_addr ^ 16'h5A5A);

  bcc_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy),
    .cpu_rdata(cpu_rdata), .cpu_err(cpu_err), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_wait(bus_wait), .bus_hold(bus_hold),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [15:0] d);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    r_cyc = 0; r_nwait = 0; r_nhold = 0; r_fw = 0; r_strobe = 1'b0;
    do begin
      @(negedge clk);
      r_cyc++;
      if (bus_wait) begin
        r_nwait++;
        if (r_fw == 0) r_fw = r_cyc;
      end
      if (bus_hold) r_nhold++;
      if (bus_rd || bus_wr) r_strobe = 1'b1;
    end while (!cpu_rdy && r_cyc < 40);
    r_rd = cpu_rdata; r_err = cpu_err; r_sel = bus_sel;
    r_bwd = bus_wdata; r_bwr = bus_wr; r_brd = bus_rd;
    cpu_req = 1'b0;
    @(negedge clk);
    r_after = cpu_rdy;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!cpu_rdy && bus_sel == 0 && !bus_rd && !bus_wr, "R8", "idle after reset",
          {cpu_rdy, bus_sel, bus_rd, bus_wr}, 0);

    // R1 reset values, R2 single-clock register access
    access(1'b0, 16'hFF00, 16'h0);
    check(r_rd == 16'h0007, "R1", "global reset", r_rd, 16'h0007);
    check(r_cyc == 1 && !r_strobe, "R2", "creg length", r_cyc, 1);
    for (int k = 1; k <= 4; k++) begin
      access(1'b0, 16'hFF00 + 16'(2 * k), 16'h0);
      check(r_rd == 16'h001F, "R1", "zone reset", r_rd, 16'h001F);
      check(r_cyc == 1 && !r_strobe && !r_err, "R2", "creg read", r_cyc, 1);
    end

    // R1/R5 slowest write out of reset: early write, W=7, H=3
    access(1'b1, 16'h2010, 16'hBEEF);
    check(r_cyc == 13, "R5", "reset early write length", r_cyc, 13);

    // R3 reserved bits
    access(1'b1, 16'hFF06, 16'hFFFF);
    access(1'b0, 16'hFF06, 16'h0);
    check(r_rd == 16'h003F, "R3", "zone reserved", r_rd, 16'h003F);
    access(1'b1, 16'hFF00, 16'h0000);
    access(1'b0, 16'hFF00, 16'h0);
    check(r_rd == 16'h0006, "R3", "global reserved", r_rd, 16'h0006);
    access(1'b1, 16'hFF00, 16'hFFF9);
    access(1'b0, 16'hFF00, 16'h0);
    check(r_rd == 16'h0007, "R3", "global bit0 only", r_rd, 16'h0007);

    // R4 R6 R7 R9 read sweep
    for (int z = 0; z < 4; z++)
      for (int f = 0; f < 2; f++)
        for (int w = 0; w < 8; w++)
          for (int h = 0; h < 4; h++) begin
            logic [15:0] a;
            int exp_t;
            access(1'b1, 16'hFF00 + 16'(2 * (z + 1)), 16'(f * 32 + h * 8 + w));
            check(r_cyc == 1, "R2", "creg write", r_cyc, 1);
            a = {1'b0, 2'(z), 13'(w * 131 + h * 17 + f * 7 + 1)};
            access(1'b0, a, 16'h0);
            exp_t = (f == 1 ? 1 : 2) + w + h;
            check(r_cyc == exp_t, "R4", "read length", r_cyc, exp_t);
            check(r_nwait == w, "R6", "wait count", r_nwait, w);
            check(w == 0 || r_fw == 2, "R6", "wait position", r_fw, 2);
            check(r_nhold == h, "R7", "hold count", r_nhold, h);
            check(r_rd == (a ^ 16'h5A5A), "R7", "read data", r_rd, a ^ 16'h5A5A);
            check(r_sel == 4'(1 << z) && r_brd && !r_err, "R9", "zone select", r_sel, 1 << z);
            check(!r_after, "R8", "ready one clock", r_after, 0);
          end

    // R5 write sweep on zone 1
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 8; w++)
        for (int h = 0; h < 4; h++) begin
          logic [15:0] d;
          int exp_t;
          access(1'b1, 16'hFF00, 16'(6 + e));
          access(1'b1, 16'hFF04, 16'(h * 8 + w));
          d = 16'(16'h1357 + w * 257 + h * 4099 + e);
          access(1'b1, 16'h2044, d);
          exp_t = (e == 1 ? 3 : 2) + w + h;
          check(r_cyc == exp_t, "R5", "write length", r_cyc, exp_t);
          check(r_bwd == d && r_bwr && !r_brd, "R5", "write data", r_bwd, d);
          check(r_nwait == w && r_nhold == h, "R6", "write wait/hold", r_nwait * 16 + r_nhold, w * 16 + h);
        end

    // R10 unmapped addresses
    begin
      logic [15:0] bad [4];
      bad[0] = 16'h8000; bad[1] = 16'hC123; bad[2] = 16'hFF01; bad[3] = 16'hFF0A;
      for (int i = 0; i < 4; i++) begin
        access(1'b0, bad[i], 16'h0);
        check(r_cyc == 2 && r_err && r_rd == 0 && !r_strobe && r_sel == 0, "R10",
              "unmapped read", {r_cyc, r_err, r_rd}, 2);
        access(1'b1, bad[i], 16'hFFFF);
        check(r_cyc == 2 && r_err && !r_strobe, "R10", "unmapped write", r_cyc, 2);
      end
      access(1'b0, 16'hFF08, 16'h0);
      check(!r_err && r_cyc == 1, "R10", "no error on valid", r_err, 0);
    end

    // R8 request held through the ready clock
    cpu_we = 1'b0; cpu_addr = 16'hFF00; cpu_req = 1'b1;
    @(negedge clk);
    check(cpu_rdy, "R8", "first ready", cpu_rdy, 1);
    cpu_addr = 16'hFF02;
    @(negedge clk);
    check(!cpu_rdy, "R8", "no accept in ready clock", cpu_rdy, 0);
    @(negedge clk);
    check(cpu_rdy && cpu_rdata == 16'h003F, "R8", "second ready", cpu_rdata, 16'h003F);
    cpu_req = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule